// File: doc/BRIEF.md
# Memory-Mapped Hart Timer

This block gives a single processor hart a 64-bit time base and one compare-driven interrupt. A tick divider runs while the block is enabled; each time it completes a period of (prescale + 1) clocks, the 64-bit count grows by a programmable step. Software can read and write the count through two 32-bit words, and can set a 64-bit compare value the same way. Whenever the compare value is at or below the count, the timer condition is true.

The block has two outputs. The first is a level interrupt that goes straight to the hart. It follows the compare condition and is held low while the block is disabled. The second is a peripheral interrupt line that comes from a sticky status bit, gated by an enable bit. Software clears the status bit by writing a 1 to it. A test register lets software set the status bit by hand. All registers sit in a 1 KiB window on a plain 32-bit strobe bus. Reads return data in the same cycle as the read strobe, and writes take effect on the clock edge where the write strobe is high.

Top module: `hart_timer`

## Requirements
- R1: After reset the registers read as follows: control 0, configuration 0x00010000 (step 1, prescale 0), both compare words 0xFFFFFFFF, both count words 0, enable 0, status 0. Both interrupt outputs are low.
- R2: Register byte offsets are control 0x000 (enable in bit 0), configuration 0x100 (prescale in bits 11:0, step in bits 23:16), count low 0x104, count high 0x108, compare low 0x10C, compare high 0x110, interrupt enable 0x114 (bit 0), status 0x118 (bit 0) and test 0x11C (bit 0). Unused bits read as 0.
- R3: While the control enable bit is 1, the count grows by the step value once every (prescale + 1) clocks, starting from a tick phase of zero after reset. While the enable bit is 0, the count and the tick phase hold their values.
- R4: A write to either count word loads that word on the write edge. For that edge, the increment is skipped for the whole 64-bit count.
- R5: The increment carries from the low word into the high word.
- R6: The timer condition is an unsigned 64-bit comparison: compare <= count. The hart interrupt output equals this condition in the same cycle while the enable bit is 1, and is 0 while the enable bit is 0.
- R7: On every clock edge where the timer condition holds, the status bit is set, whatever the interrupt enable and control enable bits are. Once set, it stays set until it is cleared.
- R8: Writing 1 to status bit 0 clears the status bit, and writing 0 leaves it unchanged. If a set and a clear land on the same edge, the set wins.
- R9: Writing 1 to test bit 0 sets the status bit. The test register always reads as 0.
- R10: The peripheral interrupt output equals the status bit AND the interrupt enable bit.
- R11: Only address bits 9:2 are decoded. Reads from unmapped offsets return 0, and writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| addr_i | input | 10 | Byte address within the register window |
| rd_i | input | 1 | Read strobe; rdata_o is valid in the same cycle |
| wr_i | input | 1 | Write strobe; the write takes effect at the rising edge |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data; 0 when no read is strobed |
| hart_irq_o | output | 1 | Level timer interrupt to the hart |
| periph_irq_o | output | 1 | Gated peripheral interrupt line |

## Verification
Two pairs of events can land on the same clock edge, and the bench forces both.

The first pair is a clear of the status bit and a set from a compare condition that still holds. The bench writes 1 to the status register while the count is already past the compare value. It expects the status bit to read back as 1. It then moves the compare value out of reach, writes 1 again, and expects the bit to read back as 0.

The second pair is a software load of a count word and a counter increment. While the counter runs with prescale 0, the bench writes the low word and then the high word on back-to-back edges. It expects each read to return exactly the values written, with no step added. One free-running cycle later, it expects the count to have advanced by exactly one step.

// File: rtl/hart_timer_pkg.sv
package hart_timer_pkg;

  localparam int unsigned HT_DATA_W   = 32;
  localparam int unsigned HT_CNT_W    = 64;
  localparam int unsigned HT_PRE_W    = 12;
  localparam int unsigned HT_STEP_W   = 8;
  localparam int unsigned HT_STEP_LSB = 16;
  localparam int unsigned HT_ADDR_W   = 10;

  // byte offsets inside the window
  localparam int unsigned OFS_CTRL   = 32'h000;
  localparam int unsigned OFS_CFG    = 32'h100;
  localparam int unsigned OFS_CNT_LO = 32'h104;
  localparam int unsigned OFS_CNT_HI = 32'h108;
  localparam int unsigned OFS_CMP_LO = 32'h10C;
  localparam int unsigned OFS_CMP_HI = 32'h110;
  localparam int unsigned OFS_IEN    = 32'h114;
  localparam int unsigned OFS_IST    = 32'h118;
  localparam int unsigned OFS_ITEST  = 32'h11C;

  typedef struct packed {
    logic ctrl;
    logic cfg;
    logic cnt_lo;
    logic cnt_hi;
    logic cmp_lo;
    logic cmp_hi;
    logic ien;
    logic ist;
    logic itest;
  } ht_sel_t;

  function automatic ht_sel_t ht_decode(input int unsigned off);
    ht_sel_t s;
    s = '0;
    case (off)
      OFS_CTRL:   s.ctrl   = 1'b1;
      OFS_CFG:    s.cfg    = 1'b1;
      OFS_CNT_LO: s.cnt_lo = 1'b1;
      OFS_CNT_HI: s.cnt_hi = 1'b1;
      OFS_CMP_LO: s.cmp_lo = 1'b1;
      OFS_CMP_HI: s.cmp_hi = 1'b1;
      OFS_IEN:    s.ien    = 1'b1;
      OFS_IST:    s.ist    = 1'b1;
      OFS_ITEST:  s.itest  = 1'b1;
      default:    s        = '0;
    endcase
    return s;
  endfunction

  // timer condition: compare at or below the count
  function automatic logic ht_reached(input logic [HT_CNT_W-1:0] cmp,
                                      input logic [HT_CNT_W-1:0] cnt);
    return cmp <= cnt;
  endfunction

  function automatic logic [HT_CNT_W-1:0] ht_advance(input logic [HT_CNT_W-1:0]  cnt,
                                                     input logic [HT_STEP_W-1:0] step);
    return cnt + HT_CNT_W'(step);
  endfunction

  function automatic logic [HT_DATA_W-1:0] ht_pack_cfg(input logic [HT_PRE_W-1:0]  pre,
                                                       input logic [HT_STEP_W-1:0] step);
    logic [HT_DATA_W-1:0] v;
    v = '0;
    v[HT_PRE_W-1:0] = pre;
    v[HT_STEP_LSB +: HT_STEP_W] = step;
    return v;
  endfunction

endpackage

// File: rtl/ht_regs.sv
module ht_regs
  import hart_timer_pkg::*;
#(
  parameter int unsigned DATA_W = HT_DATA_W,
  parameter int unsigned CNT_W  = HT_CNT_W,
  parameter int unsigned PRE_W  = HT_PRE_W,
  parameter int unsigned STEP_W = HT_STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  ht_sel_t           wsel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              active_o,
  output logic [PRE_W-1:0]  prescale_o,
  output logic [STEP_W-1:0] step_o,
  output logic [CNT_W-1:0]  cmp_o,
  output logic              ien_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic [HALVES-1:0] cmp_wr;
  assign cmp_wr = {wsel_i.cmp_hi, wsel_i.cmp_lo};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o   <= 1'b0;
      prescale_o <= '0;
      step_o     <= STEP_W'(1);
      ien_o      <= 1'b0;
    end else begin
      if (wsel_i.ctrl) active_o <= wdata_i[0];
      if (wsel_i.cfg) begin
        prescale_o <= wdata_i[PRE_W-1:0];
        step_o     <= wdata_i[HT_STEP_LSB +: STEP_W];
      end
      if (wsel_i.ien) ien_o <= wdata_i[0];
    end
  end

  for (genvar h = 0; h < HALVES; h++) begin : g_cmp_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        cmp_o[h*DATA_W +: DATA_W] <= '1;
      else if (cmp_wr[h]) cmp_o[h*DATA_W +: DATA_W] <= wdata_i;
    end
  end

endmodule

// File: rtl/ht_count.sv
module ht_count
  import hart_timer_pkg::*;
#(
  parameter int unsigned DATA_W = HT_DATA_W,
  parameter int unsigned CNT_W  = HT_CNT_W,
  parameter int unsigned PRE_W  = HT_PRE_W,
  parameter int unsigned STEP_W = HT_STEP_W
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       active_i,
  input  logic [PRE_W-1:0]           prescale_i,
  input  logic [STEP_W-1:0]          step_i,
  input  logic [CNT_W/DATA_W-1:0]    wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  output logic [CNT_W-1:0]           cnt_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic [PRE_W-1:0] tick_q;
  logic             tick_wrap;
  logic [CNT_W-1:0] cnt_d;

  // >= keeps the divider from running away if prescale shrinks mid-period
  assign tick_wrap = active_i && (tick_q >= prescale_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       tick_q <= '0;
    else if (active_i) tick_q <= tick_wrap ? '0 : tick_q + PRE_W'(1);
  end

  always_comb begin
    cnt_d = cnt_o;
    if (|wr_i) begin
      for (int h = 0; h < HALVES; h++) begin
        if (wr_i[h]) cnt_d[h*DATA_W +: DATA_W] = wdata_i;
      end
    end else if (tick_wrap) begin
      cnt_d = ht_advance(cnt_o, step_i);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_o <= '0;
    else         cnt_o <= cnt_d;
  end

  // R3: a disabled, unwritten counter holds
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && wr_i == '0) |=> $stable(cnt_o));

  // R3: a divider wrap adds exactly one step
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_wrap && wr_i == '0) |=> cnt_o == $past(cnt_o) + CNT_W'($past(step_i)));

  // R4: a software load wins over the increment
  a_r4_load_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i[0] |=> cnt_o[DATA_W-1:0] == $past(wdata_i));

endmodule

// File: rtl/ht_intr.sv
module ht_intr
  import hart_timer_pkg::*;
#(
  parameter int unsigned CNT_W = HT_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic [CNT_W-1:0] cmp_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             ien_i,
  input  logic             clr_req_i,
  input  logic             test_req_i,
  output logic             status_o,
  output logic             hart_irq_o,
  output logic             periph_irq_o
);
  logic cond;
  logic set_evt;

  assign cond    = ht_reached(cmp_i, cnt_i);
  assign set_evt = cond | test_req_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_o <= 1'b0;
    else         status_o <= set_evt | (status_o & ~clr_req_i);
  end

  assign hart_irq_o   = active_i & cond;
  assign periph_irq_o = status_o & ien_i;

  // R7: a set event always lands in status, even against a clear
  a_r7_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt |=> status_o);

  // R7: status is sticky without a clear
  a_r7_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o && !clr_req_i) |=> status_o);

  // R8: a clear with no competing set empties status
  a_r8_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_req_i && !set_evt) |=> !status_o);

endmodule

// File: rtl/hart_timer.sv
module hart_timer
  import hart_timer_pkg::*;
#(
  parameter int unsigned ADDR_W = HT_ADDR_W,
  parameter int unsigned DATA_W = HT_DATA_W,
  parameter int unsigned CNT_W  = HT_CNT_W,
  parameter int unsigned PRE_W  = HT_PRE_W,
  parameter int unsigned STEP_W = HT_STEP_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              hart_irq_o,
  output logic              periph_irq_o
);
  localparam int unsigned HALVES = CNT_W / DATA_W;

  logic [ADDR_W-1:0] word_off;
  ht_sel_t           sel;
  ht_sel_t           wsel;
  logic              unused_lsb;

  logic              active;
  logic [PRE_W-1:0]  prescale;
  logic [STEP_W-1:0] step;
  logic [CNT_W-1:0]  cmp;
  logic              ien;
  logic [CNT_W-1:0]  cnt;
  logic              status;

  assign word_off   = {addr_i[ADDR_W-1:2], 2'b00};
  assign unused_lsb = ^addr_i[1:0];
  assign sel        = ht_decode(32'(word_off));
  assign wsel       = wr_i ? sel : '0;

  ht_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .STEP_W(STEP_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wsel_i     (wsel),
    .wdata_i    (wdata_i),
    .active_o   (active),
    .prescale_o (prescale),
    .step_o     (step),
    .cmp_o      (cmp),
    .ien_o      (ien)
  );

  ht_count #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PRE_W(PRE_W), .STEP_W(STEP_W)) u_count (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .active_i   (active),
    .prescale_i (prescale),
    .step_i     (step),
    .wr_i       (HALVES'({wsel.cnt_hi, wsel.cnt_lo})),
    .wdata_i    (wdata_i),
    .cnt_o      (cnt)
  );

  ht_intr #(.CNT_W(CNT_W)) u_intr (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .active_i     (active),
    .cmp_i        (cmp),
    .cnt_i        (cnt),
    .ien_i        (ien),
    .clr_req_i    (wsel.ist & wdata_i[0]),
    .test_req_i   (wsel.itest & wdata_i[0]),
    .status_o     (status),
    .hart_irq_o   (hart_irq_o),
    .periph_irq_o (periph_irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_i) begin
      if (sel.ctrl)   rdata_o[0] = active;
      if (sel.cfg)    rdata_o    = ht_pack_cfg(prescale, step);
      if (sel.cnt_lo) rdata_o    = cnt[DATA_W-1:0];
      if (sel.cnt_hi) rdata_o    = cnt[DATA_W +: DATA_W];
      if (sel.cmp_lo) rdata_o    = cmp[DATA_W-1:0];
      if (sel.cmp_hi) rdata_o    = cmp[DATA_W +: DATA_W];
      if (sel.ien)    rdata_o[0] = ien;
      if (sel.ist)    rdata_o[0] = status;
    end
  end

  // R11: unmapped reads are zero
  a_r11_unmapped_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && sel == '0) |-> rdata_o == '0);

  // R6: the hart line is never up while disabled
  a_r6_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(active) |-> !hart_irq_o);

endmodule

// File: tb/tb_hart_timer.sv
module tb_hart_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [9:0]  addr = '0;
  logic        rd = 1'b0;
  logic        wr = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        hart_irq;
  logic        periph_irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  hart_timer dut (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .addr_i       (addr),
    .rd_i         (rd),
    .wr_i         (wr),
    .wdata_i      (wdata),
    .rdata_o      (rdata),
    .hart_irq_o   (hart_irq),
    .periph_irq_o (periph_irq)
  );

  localparam logic [9:0] A_CTRL = 10'h000, A_CFG = 10'h100, A_CLO = 10'h104,
                         A_CHI = 10'h108, A_MLO = 10'h10C, A_MHI = 10'h110,
                         A_IEN = 10'h114, A_IST = 10'h118, A_ITS = 10'h11C;

  typedef struct packed {
    logic [11:0] pre;
    logic [7:0]  step;
    logic [15:0] cyc;
    logic [31:0] exp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{12'd0, 8'd1,   16'd10, 32'd10},
    '{12'd3, 8'd1,   16'd10, 32'd2},
    '{12'd2, 8'd5,   16'd9,  32'd15},
    '{12'd0, 8'd0,   16'd7,  32'd0},
    '{12'd1, 8'd255, 16'd6,  32'd765}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(input logic [9:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [9:0] a, output logic [31:0] d);
    addr = a; rd = 1'b1;
    #1 d = rdata;
    rd = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_rd(a, v);
    chk(req, v, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    do_reset();

    // R1: reset values
    rd_chk("R1 ctrl",   A_CTRL, 32'h0);
    rd_chk("R1 cfg",    A_CFG,  32'h0001_0000);
    rd_chk("R1 cmp_lo", A_MLO,  32'hFFFF_FFFF);
    rd_chk("R1 cmp_hi", A_MHI,  32'hFFFF_FFFF);
    rd_chk("R1 cnt_lo", A_CLO,  32'h0);
    rd_chk("R1 cnt_hi", A_CHI,  32'h0);
    rd_chk("R1 ien",    A_IEN,  32'h0);
    rd_chk("R1 ist",    A_IST,  32'h0);
    chk("R1 hart_irq", {31'b0, hart_irq}, 32'h0);
    chk("R1 periph_irq", {31'b0, periph_irq}, 32'h0);

    // R3: prescale/step table, run for cyc edges from tick phase 0
    for (int i = 0; i < 5; i++) begin
      logic [31:0] cfgv;
      do_reset();
      cfgv = {8'h00, VECS[i].step, 4'h0, VECS[i].pre};
      bus_wr(A_CFG, cfgv);
      rd_chk("R2 cfg fields", A_CFG, cfgv);
      bus_wr(A_CTRL, 32'h1);
      idle(int'(VECS[i].cyc) - 1);
      bus_wr(A_CTRL, 32'h0);
      rd_chk("R3 count", A_CLO, VECS[i].exp);
      rd_chk("R3 count hi", A_CHI, 32'h0);
      idle(3);
      rd_chk("R3 hold while disabled", A_CLO, VECS[i].exp);
    end

    // R11 / R2: unmapped, ignored low address bits, ctrl width
    do_reset();
    rd_chk("R11 unmapped read", 10'h200, 32'h0);
    bus_wr(10'h204, 32'hFFFF_FFFF);
    rd_chk("R11 unmapped write ignored", A_CFG, 32'h0001_0000);
    rd_chk("R11 low bits ignored", 10'h10E, 32'hFFFF_FFFF);
    bus_wr(A_CTRL, 32'hFFFF_FFFE);
    rd_chk("R2 ctrl bit0 only", A_CTRL, 32'h0);

    // R5: carry into the high word
    do_reset();
    bus_wr(A_CLO, 32'hFFFF_FFFE);
    bus_wr(A_CFG, 32'h0002_0000);
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_CTRL, 32'h0);
    rd_chk("R5 carry lo", A_CLO, 32'h0);
    rd_chk("R5 carry hi", A_CHI, 32'h1);

    // R4: count load collides with the increment
    do_reset();
    bus_wr(A_CTRL, 32'h1);
    bus_wr(A_CLO, 32'd50);
    rd_chk("R4 low load wins", A_CLO, 32'd50);
    bus_wr(A_CHI, 32'd7);
    rd_chk("R4 high load freezes low", A_CLO, 32'd50);
    rd_chk("R4 high loaded", A_CHI, 32'd7);
    idle(1);
    rd_chk("R4 resumes", A_CLO, 32'd51);

    // R6 / R7 / R10: compare crossing
    do_reset();
    bus_wr(A_CLO, 32'd100);
    bus_wr(A_MHI, 32'h0);
    bus_wr(A_MLO, 32'd105);
    bus_wr(A_IEN, 32'h1);
    chk("R6 not reached", {31'b0, hart_irq}, 32'h0);
    rd_chk("R7 no status yet", A_IST, 32'h0);
    bus_wr(A_CTRL, 32'h1);
    idle(4);
    chk("R6 count 104 below compare", {31'b0, hart_irq}, 32'h0);
    idle(1);
    chk("R6 count 105 reaches compare", {31'b0, hart_irq}, 32'h1);
    chk("R10 status not yet set", {31'b0, periph_irq}, 32'h0);
    idle(1);
    chk("R10 periph follows status", {31'b0, periph_irq}, 32'h1);
    bus_wr(A_CTRL, 32'h0);
    chk("R6 disabled forces low", {31'b0, hart_irq}, 32'h0);

    // R8: clear against a live set, then real clear
    bus_wr(A_IST, 32'h1);
    rd_chk("R8 set wins over clear", A_IST, 32'h1);
    bus_wr(A_MHI, 32'hFFFF_FFFF);
    bus_wr(A_IST, 32'h0);
    rd_chk("R8 write 0 no effect", A_IST, 32'h1);
    bus_wr(A_IST, 32'h1);
    rd_chk("R8 write 1 clears", A_IST, 32'h0);
    chk("R10 periph low after clear", {31'b0, periph_irq}, 32'h0);

    // R9 / R10: test bit
    bus_wr(A_IEN, 32'h0);
    bus_wr(A_ITS, 32'h1);
    rd_chk("R9 test sets status", A_IST, 32'h1);
    rd_chk("R9 test reads zero", A_ITS, 32'h0);
    chk("R10 gated by enable", {31'b0, periph_irq}, 32'h0);
    bus_wr(A_IEN, 32'h1);
    chk("R10 enabled", {31'b0, periph_irq}, 32'h1);
    bus_wr(A_IST, 32'h1);

    // R7: status sets while the block is disabled
    bus_wr(A_MHI, 32'h0);
    idle(1);
    rd_chk("R7 set while disabled", A_IST, 32'h1);
    chk("R6 hart low while disabled", {31'b0, hart_irq}, 32'h0);

    // R6: full 64-bit comparison
    bus_wr(A_CHI, 32'h1);
    bus_wr(A_CLO, 32'h0);
    bus_wr(A_MHI, 32'h1);
    bus_wr(A_MLO, 32'h1);
    bus_wr(A_IST, 32'h1);
    idle(1);
    rd_chk("R6 high word compare above", A_IST, 32'h0);
    bus_wr(A_MLO, 32'h0);
    idle(1);
    rd_chk("R6 equal 64-bit reached", A_IST, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule